// File: doc/BRIEF.md
# Tick-Started Serial Clock Burst Generator

This block generates the master serial clock shared by an external A/D converter and a serial port that runs as a clock slave. The clock does not run all the time. Each rising edge of a periodic timer tick starts a burst of the slow serial clock. The burst runs until the converter raises its end-of-conversion line, which it does after its sixteen clocks. The clock then stays parked low until the next tick. If end-of-conversion never arrives, a safety count ends the burst anyway.

The block also holds a small write-only control register with three bits. The converter-reset bit (bit 7) drives the converter reset output. While it is set, the serial clock is cleared and no burst can start. The supply-drive bit (bit 5) gates a faster clock that drives the front-end supply transformer; clearing the bit and setting it again power-cycles the front end. The program-enable bit (bit 6) drives the flash program-enable level.

The timer tick and end-of-conversion inputs pass through synchronizers before their rising edges are detected. The serial and supply clock half-periods are counted in system clock cycles.

Top module: `tick_sclk_burst`

## Requirements
- R1: While a burst runs, the serial clock has a period of 2*SCLK_HALF system cycles and a 50% duty cycle (25 kHz from 50 MHz with the default SCLK_HALF of 1000).
- R2: A rising edge of the tick input starts a burst. The synchronizer and edge detector take three cycles, so with two synchronizer stages `sclk_o` first rises exactly 3+SCLK_HALF cycles after `tick_i` rises. Every burst opens with a full low half-period.
- R3: A rising edge of `eoc_i` ends the burst. `sclk_o` then stays low, with no further edges, until the next accepted tick. A burst ended in this way after the sixteenth rising edge shows exactly 16 rising edges.
- R4: While a burst is active, tick edges are ignored. A tick held high across the end of a burst does not start a second burst.
- R5: If end-of-conversion never arrives, the burst ends after MAX_CYCLES complete serial clock cycles (default 32) and `sclk_o` parks low.
- R6: Control bit 7 drives `adc_rst_o` one cycle after the write. While the bit is set, `sclk_o` is held low, ticks start nothing, and a burst in progress is aborted.
- R7: While control bit 5 is set, `supply_clk_o` toggles every SUPPLY_HALF cycles. While the bit is clear, `supply_clk_o` stays low.
- R8: `prog_en_o` equals control bit 6, one cycle after the write.
- R9: After reset the control register is zero and all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick; each rising edge may start a burst |
| eoc_i | input | 1 | Converter end-of-conversion; a rising edge ends the burst |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data; bit 5 supply drive, bit 6 program enable, bit 7 converter reset |
| sclk_o | output | 1 | Burst serial clock, parked low when idle |
| adc_rst_o | output | 1 | Converter reset level |
| supply_clk_o | output | 1 | Gated supply-transformer drive clock |
| prog_en_o | output | 1 | Flash program-enable level |

## Verification
Bursts are started with a short tick pulse and ended by end-of-conversion. This checks the start latency, the half-period widths and the exact edge count. A second tick pulse in mid-burst and a tick held high past the end of the burst separate edge detection from level detection and show that a running burst is not restarted. A burst with no end-of-conversion exposes the 32-cycle limit. A converter-reset write in the middle of a high phase shows an abort, as opposed to a burst that simply runs to its end. Writes of the supply and program bits, alone and together, show that each output follows only its own bit.

// File: rtl/tick_sclk_burst_pkg.sv
package tick_sclk_burst_pkg;
   localparam int CTRL_W        = 8;
   localparam int SUPPLY_BIT    = 5;
   localparam int PROG_BIT      = 6;
   localparam int CONV_RST_BIT  = 7;

   typedef struct packed {
      logic conv_rst;
      logic prog;
      logic supply;
   } ctrl_t;

   typedef enum logic {
      BURST_IDLE = 1'b0,
      BURST_RUN  = 1'b1
   } burst_state_e;
endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tsb_halfdiv.sv
module tsb_halfdiv #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic clk_o,
   output logic fall_next_o
);
   if (HALF < 2) begin : g_bad_half
      $error("tsb_halfdiv: HALF must be at least 2");
   end

   localparam int CW = $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt;
   logic          out_q;
   logic          wrap;

   assign wrap = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         out_q <= 1'b0;
      end else if (!run_i) begin
         cnt   <= '0;
         out_q <= 1'b0;
      end else if (wrap) begin
         cnt   <= '0;
         out_q <= ~out_q;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign clk_o       = out_q;
   assign fall_next_o = run_i & wrap & out_q;

   // R2: the cycle in which run first appears still shows a low output
   assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> !out_q);

   // R1: the output only changes phase after a full half period
   assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && (out_q != $past(out_q))) |-> ($past(cnt) == LAST));

   // R3/R5: a stopped divider parks low
   assert_park_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !out_q);
endmodule

// File: rtl/tsb_burst_ctrl.sv
module tsb_burst_ctrl
   import tick_sclk_burst_pkg::*;
#(
   parameter int MAX_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic hold_off_i,
   input  logic fall_next_i,
   output logic run_o
);
   if (MAX_CYCLES < 1) begin : g_bad_max
      $error("tsb_burst_ctrl: MAX_CYCLES must be at least 1");
   end

   localparam int CCW = $clog2(MAX_CYCLES + 1);
   localparam logic [CCW-1:0] LAST_CYC = CCW'(MAX_CYCLES - 1);

   burst_state_e   state;
   logic [CCW-1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= BURST_IDLE;
         cyc   <= '0;
      end else begin
         unique case (state)
            BURST_IDLE: begin
               cyc <= '0;
               if (start_i && !hold_off_i) state <= BURST_RUN;
            end
            BURST_RUN: begin
               if (hold_off_i || stop_i) begin
                  state <= BURST_IDLE;
               end else if (fall_next_i) begin
                  if (cyc == LAST_CYC) state <= BURST_IDLE;
                  else                 cyc   <= cyc + 1'b1;
               end
            end
            default: state <= BURST_IDLE;
         endcase
      end
   end

   assign run_o = (state == BURST_RUN);

   // R5: the completed-cycle count never reaches the limit while running
   assert_cycle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (cyc < CCW'(MAX_CYCLES)));

   // R6: converter reset stops and blocks any burst
   assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_off_i |=> !run_o);

   // R4: a start request while running changes nothing
   assert_ignore_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && start_i && !stop_i && !hold_off_i && !fall_next_i)
         |=> (run_o && cyc == $past(cyc)));
endmodule

// File: rtl/tick_sclk_burst.sv
module tick_sclk_burst
   import tick_sclk_burst_pkg::*;
#(
   parameter int SCLK_HALF   = 1000,
   parameter int SUPPLY_HALF = 125,
   parameter int MAX_CYCLES  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              eoc_i,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   output logic              sclk_o,
   output logic              adc_rst_o,
   output logic              supply_clk_o,
   output logic              prog_en_o
);
   if (CONV_RST_BIT >= CTRL_W || PROG_BIT >= CTRL_W || SUPPLY_BIT >= CTRL_W) begin : g_bad_map
      $error("tick_sclk_burst: control bit outside register width");
   end

   // control register
   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en_i) begin
         ctrl_q.conv_rst <= wr_data_i[CONV_RST_BIT];
         ctrl_q.prog     <= wr_data_i[PROG_BIT];
         ctrl_q.supply   <= wr_data_i[SUPPLY_BIT];
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data_i[SUPPLY_BIT-1:0];

   // input synchronizers and rising-edge detection
   logic tick_s, eoc_s, tick_prev, eoc_prev;

   tsb_sync #(.STAGES(SYNC_STAGES)) u_sync_tick (
      .clk(clk), .rst_n(rst_n), .d_i(tick_i), .q_o(tick_s));

   tsb_sync #(.STAGES(SYNC_STAGES)) u_sync_eoc (
      .clk(clk), .rst_n(rst_n), .d_i(eoc_i), .q_o(eoc_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_prev <= 1'b0;
         eoc_prev  <= 1'b0;
      end else begin
         tick_prev <= tick_s;
         eoc_prev  <= eoc_s;
      end
   end

   logic tick_rise, eoc_rise;
   assign tick_rise = tick_s & ~tick_prev;
   assign eoc_rise  = eoc_s & ~eoc_prev;

   // burst sequencing
   logic run, sclk_raw, sclk_fall_next;

   tsb_burst_ctrl #(.MAX_CYCLES(MAX_CYCLES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (tick_rise),
      .stop_i     (eoc_rise),
      .hold_off_i (ctrl_q.conv_rst),
      .fall_next_i(sclk_fall_next),
      .run_o      (run)
   );

   tsb_halfdiv #(.HALF(SCLK_HALF)) u_sclk_div (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .clk_o(sclk_raw), .fall_next_o(sclk_fall_next));

   // supply drive clock
   logic supply_fall_unused;

   tsb_halfdiv #(.HALF(SUPPLY_HALF)) u_supply_div (
      .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.supply),
      .clk_o(supply_clk_o), .fall_next_o(supply_fall_unused));

   assign sclk_o    = sclk_raw & run;
   assign adc_rst_o = ctrl_q.conv_rst;
   assign prog_en_o = ctrl_q.prog;

   // R8: program enable follows the written bit
   assert_prog_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (prog_en_o == $past(wr_data_i[PROG_BIT])));

   // R6: converter reset follows its bit and silences the serial clock
   assert_rst_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (adc_rst_o == $past(wr_data_i[CONV_RST_BIT])));

   assert_rst_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_rst_o |=> !sclk_o);

   // R7: supply clock stays low while its enable is clear
   assert_supply_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.supply && !$past(ctrl_q.supply)) |-> !supply_clk_o);
endmodule

// File: tb/tb_tick_sclk_burst.sv
module tb_tick_sclk_burst;
   localparam int HALF   = 4;
   localparam int SHALF  = 3;
   localparam int MAXC   = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       eoc_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       sclk_o, adc_rst_o, supply_clk_o, prog_en_o;

   tick_sclk_burst #(
      .SCLK_HALF(HALF), .SUPPLY_HALF(SHALF), .MAX_CYCLES(MAXC), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .eoc_i(eoc_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .sclk_o(sclk_o), .adc_rst_o(adc_rst_o),
      .supply_clk_o(supply_clk_o), .prog_en_o(prog_en_o)
   );

   always #10 clk = ~clk;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   // scoreboard: expected rising-edge count per burst
   int  exp_q[$];
   int  rises = 0;
   bit  sclk_prev = 0;
   bit  close_req = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (sclk_o && !sclk_prev) rises++;
      sclk_prev = sclk_o;
      if (close_req) begin
         if (exp_q.size() == 0) chk("scoreboard empty", 1, 0);
         else chk("burst edge count (R3/R4/R5/R6)", rises, exp_q.pop_front());
         rises = 0;
         close_req = 0;
      end
   end

   task automatic close_burst();
      close_req = 1;
      while (close_req) @(negedge clk);
   endtask

   task automatic wait_rises(input int n);
      while (rises < n) @(negedge clk);
   endtask

   task automatic wait_sclk(input logic v);
      @(negedge clk);
      while (sclk_o !== v) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk);
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic raise_eoc();
      wait_sclk(1'b0);
      eoc_i = 1'b1;
      repeat (5) @(negedge clk);
      eoc_i = 1'b0;
   endtask

   task automatic idle_low(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sclk_o) seen++;
      end
      chk(req, seen, 0);
   endtask

   // watchdog
   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int lat, w;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 sclk after reset", sclk_o, 0);
      chk("R9 adc_rst after reset", adc_rst_o, 0);
      chk("R9 supply after reset", supply_clk_o, 0);
      chk("R9 prog after reset", prog_en_o, 0);
      rst_n = 1'b1;
      idle_low(20, "R9 no clock without tick");

      // Burst A: latency, widths, eoc stop (R1 R2 R3)
      exp_q.push_back(16);
      @(negedge clk); tick_i = 1'b1; lat = 0;
      while (!sclk_o) begin
         @(negedge clk); lat++;
         if (lat == 2) tick_i = 1'b0;
      end
      chk("R2 tick to first sclk rise", lat, 3 + HALF);
      w = 0; while (sclk_o) begin @(negedge clk); w++; end
      chk("R1 high half period", w, HALF);
      w = 0; while (!sclk_o) begin @(negedge clk); w++; end
      chk("R1 low half period", w, HALF);
      wait_rises(16);
      raise_eoc();
      idle_low(40, "R3 parked low after eoc");
      close_burst();

      // Burst B: second tick mid-burst ignored (R4)
      exp_q.push_back(16);
      pulse_tick();
      wait_rises(5);
      pulse_tick();
      wait_rises(16);
      raise_eoc();
      idle_low(60, "R4 mid-burst tick started nothing");
      close_burst();

      // Burst C: tick held high across the burst end (R4)
      exp_q.push_back(16);
      @(negedge clk); tick_i = 1'b1;
      wait_rises(16);
      raise_eoc();
      idle_low(60, "R4 held tick no restart");
      tick_i = 1'b0;
      close_burst();

      // Burst D: no eoc, safety limit (R5)
      exp_q.push_back(MAXC);
      pulse_tick();
      repeat (2 * HALF * (MAXC + 4)) @(negedge clk);
      chk("R5 sclk low after limit", sclk_o, 0);
      close_burst();

      // R6: converter reset blocks ticks
      wr(8'h80);
      chk("R6 adc_rst set", adc_rst_o, 1);
      exp_q.push_back(0);
      pulse_tick();
      idle_low(40, "R6 tick blocked in reset");
      close_burst();
      wr(8'h00);
      chk("R6 adc_rst cleared", adc_rst_o, 0);

      // R6: abort in the middle of a high phase
      exp_q.push_back(5);
      pulse_tick();
      wait_rises(4);
      wait_sclk(1'b0);
      wait_sclk(1'b1);
      wr(8'h80);
      @(negedge clk);
      chk("R6 abort drops sclk", sclk_o, 0);
      idle_low(40, "R6 stays low while reset");
      close_burst();
      wr(8'h00);

      // R7: supply clock
      wr(8'h20);
      chk("R7 prog untouched", prog_en_o, 0);
      chk("R7 adc_rst untouched", adc_rst_o, 0);
      while (!supply_clk_o) @(negedge clk);
      w = 0; while (supply_clk_o) begin @(negedge clk); w++; end
      chk("R7 supply high width", w, SHALF);
      w = 0; while (!supply_clk_o) begin @(negedge clk); w++; end
      chk("R7 supply low width", w, SHALF);
      wr(8'h00);
      @(negedge clk);
      w = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (supply_clk_o) w++;
      end
      chk("R7 supply stays low when off", w, 0);

      // R8: program enable
      wr(8'h40);
      chk("R8 prog set", prog_en_o, 1);
      chk("R8 supply still off", supply_clk_o, 0);
      wr(8'h60);
      chk("R8 prog with supply", prog_en_o, 1);
      wr(8'h00);
      chk("R8 prog cleared", prog_en_o, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule